// File: doc/BRIEF.md
# SDRAM Open-Row Bank Tracker

This block holds, for each bank of an SDRAM device, an "open" flag and the row address latched into that bank's sense amplifiers. A command scheduler presents the bank and row of a pending read or write on the query port. It gets back, in the same cycle, what has to happen before the access may go out. If the row is already open, nothing is needed. If the bank is closed, an activate is needed. If a different row is open, a precharge and then an activate are needed.

The scheduler reports every bank-management event it issues. These are activate, single-bank precharge, precharge-all, a read or write that carried auto-precharge, and periodic refresh. The tracker updates its table on the next clock edge. Every bank can keep its own row open at the same time. A row stays open after a plain read or write and never closes because of idleness. Only a precharge, an auto-precharge access, a precharge-all or a refresh closes it.

Top module: `bank_row_tracker`

## Requirements
- R1: After reset every bank is closed: `openMask` is all zeros and every query returns the idle code.
- R2: A query to an open bank whose stored row equals `qRow` returns the hit code 2'b00.
- R3: A query to a closed bank returns the idle code 2'b01, whatever `qRow` is.
- R4: A query to an open bank whose stored row differs from `qRow` returns the conflict code 2'b10. The value 2'b11 never appears on `qResult`.
- R5: An activate event stores `actRow` for bank `actBank` and sets that bank's bit in `openMask` on the next edge. This replaces any row stored there before. `qOpenRow` shows the stored row of the queried bank when it is open, and zero when it is closed.
- R6: A precharge event closes bank `preBank` on the next edge and leaves all other banks unchanged.
- R7: An auto-precharge event closes bank `apBank` on the next edge and leaves all other banks unchanged.
- R8: A precharge-all event closes every bank in a single cycle.
- R9: A refresh event closes every bank in a single cycle.
- R10: A precharge-all or refresh in the same cycle overrides an activate, so all banks end closed. An activate overrides a precharge or auto-precharge aimed at the same bank in the same cycle, so that bank ends open with the new row.
- R11: Banks are independent. In a cycle with no event, the open flags and stored rows all stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| qBank | input | BANK_W | Bank of the pending access |
| qRow | input | ROW_W | Row of the pending access |
| qResult | output | 2 | 00 hit, 01 idle, 10 conflict |
| qOpenRow | output | ROW_W | Row open in the queried bank, zero when closed |
| actEn | input | 1 | Activate issued this cycle |
| actBank | input | BANK_W | Bank being activated |
| actRow | input | ROW_W | Row being activated |
| preEn | input | 1 | Single-bank precharge issued this cycle |
| preBank | input | BANK_W | Bank being precharged |
| apEn | input | 1 | Access with auto-precharge issued this cycle |
| apBank | input | BANK_W | Bank of the auto-precharge access |
| preAllEn | input | 1 | Precharge-all issued this cycle |
| refEn | input | 1 | Refresh issued this cycle |
| openMask | output | BANKS | One open flag per bank |

## Verification
The assertions assume that `BANKS` is a power of two, so every bank index on the query and event ports names a real bank. They also assume that the event strobes are never unknown while reset is released. Under those assumptions they relate each event to the open flags one edge later. The bench uses a four-bank, three-bit-row configuration, so after every event it can sweep every bank and row pair through the query port against its own model. The bench drives every event on the falling edge, so the bench and the design never change inputs and state at the same edge. Its event mix includes the same-cycle collisions of R10 on purpose.

// File: rtl/brt_pkg.sv
package brt_pkg;

  typedef enum logic [1:0] {
    LK_HIT      = 2'b00,
    LK_IDLE     = 2'b01,
    LK_CONFLICT = 2'b10
  } lookup_e;

  // Priority-resolved update strobes from control to datapath
  typedef struct packed {
    logic setRow;   // activate, already masked by close-all
    logic clrBank;  // single-bank precharge
    logic clrAuto;  // auto-precharge access
    logic clrAll;   // precharge-all or refresh
  } upd_s;

endpackage

// File: rtl/brt_ctrl.sv
module brt_ctrl
  import brt_pkg::*;
(
  input  logic actEn,
  input  logic preEn,
  input  logic apEn,
  input  logic preAllEn,
  input  logic refEn,
  output upd_s upd
);

  logic closeEverything;

  always_comb begin
    closeEverything = preAllEn | refEn;
    upd.clrAll  = closeEverything;
    upd.setRow  = actEn & ~closeEverything;
    upd.clrBank = preEn & ~closeEverything;
    upd.clrAuto = apEn & ~closeEverything;
  end

endmodule

// File: rtl/brt_datapath.sv
module brt_datapath
  import brt_pkg::*;
#(
  parameter int BANKS  = 8,
  parameter int ROW_W  = 14,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  upd_s              upd,
  input  logic [BANK_W-1:0] actBank,
  input  logic [ROW_W-1:0]  actRow,
  input  logic [BANK_W-1:0] preBank,
  input  logic [BANK_W-1:0] apBank,
  input  logic [BANK_W-1:0] qBank,
  input  logic [ROW_W-1:0]  qRow,
  output lookup_e           qResult,
  output logic [ROW_W-1:0]  qOpenRow,
  output logic [BANKS-1:0]  openMask
);

  logic [BANKS-1:0]            validQ;
  logic [BANKS-1:0][ROW_W-1:0] rowQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      rowQ   <= '0;
    end else begin
      for (int b = 0; b < BANKS; b++) begin
        if (upd.clrAll) begin
          validQ[b] <= 1'b0;
        end else if (upd.setRow && (actBank == BANK_W'(b))) begin
          validQ[b] <= 1'b1;
          rowQ[b]   <= actRow;
        end else if ((upd.clrBank && (preBank == BANK_W'(b))) ||
                     (upd.clrAuto && (apBank == BANK_W'(b)))) begin
          validQ[b] <= 1'b0;
        end
      end
    end
  end

  logic             selOpen;
  logic [ROW_W-1:0] selRow;

  always_comb begin
    selOpen = validQ[qBank];
    selRow  = rowQ[qBank];
    if (!selOpen) begin
      qResult = LK_IDLE;
    end else if (selRow == qRow) begin
      qResult = LK_HIT;
    end else begin
      qResult = LK_CONFLICT;
    end
    qOpenRow = selOpen ? selRow : '0;
  end

  assign openMask = validQ;

endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker
  import brt_pkg::*;
#(
  parameter int BANKS  = 8,
  parameter int ROW_W  = 14,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BANK_W-1:0] qBank,
  input  logic [ROW_W-1:0]  qRow,
  output logic [1:0]        qResult,
  output logic [ROW_W-1:0]  qOpenRow,
  input  logic              actEn,
  input  logic [BANK_W-1:0] actBank,
  input  logic [ROW_W-1:0]  actRow,
  input  logic              preEn,
  input  logic [BANK_W-1:0] preBank,
  input  logic              apEn,
  input  logic [BANK_W-1:0] apBank,
  input  logic              preAllEn,
  input  logic              refEn,
  output logic [BANKS-1:0]  openMask
);

  upd_s    upd;
  lookup_e lookup;

  brt_ctrl u_ctrl (
    .actEn    (actEn),
    .preEn    (preEn),
    .apEn     (apEn),
    .preAllEn (preAllEn),
    .refEn    (refEn),
    .upd      (upd)
  );

  brt_datapath #(.BANKS(BANKS), .ROW_W(ROW_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .upd      (upd),
    .actBank  (actBank),
    .actRow   (actRow),
    .preBank  (preBank),
    .apBank   (apBank),
    .qBank    (qBank),
    .qRow     (qRow),
    .qResult  (lookup),
    .qOpenRow (qOpenRow),
    .openMask (openMask)
  );

  assign qResult = lookup;

endmodule

// File: rtl/bank_row_tracker_chk.sv
module bank_row_tracker_chk #(
  parameter int BANKS  = 8,
  parameter int ROW_W  = 14,
  localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [BANK_W-1:0] qBank,
  input logic [ROW_W-1:0]  qRow,
  input logic [1:0]        qResult,
  input logic [ROW_W-1:0]  qOpenRow,
  input logic              actEn,
  input logic [BANK_W-1:0] actBank,
  input logic [ROW_W-1:0]  actRow,
  input logic              preEn,
  input logic [BANK_W-1:0] preBank,
  input logic              apEn,
  input logic [BANK_W-1:0] apBank,
  input logic              preAllEn,
  input logic              refEn,
  input logic [BANKS-1:0]  openMask
);

  a_r1_closed_out_of_reset: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (openMask == '0));

  a_r2_hit_needs_open: assert property (@(posedge clk) disable iff (!rstN)
    (qResult == 2'b00) |-> (openMask[qBank] && (qOpenRow == qRow)));

  a_r3_idle_means_closed: assert property (@(posedge clk) disable iff (!rstN)
    (qResult == 2'b01) |-> !openMask[qBank]);

  a_r4_no_code_three: assert property (@(posedge clk) disable iff (!rstN)
    qResult != 2'b11);

  a_r5_activate_opens: assert property (@(posedge clk) disable iff (!rstN)
    (actEn && !preAllEn && !refEn) |=> openMask[$past(actBank)]);

  a_r6_precharge_closes: assert property (@(posedge clk) disable iff (!rstN)
    (preEn && !(actEn && actBank == preBank)) |=> !openMask[$past(preBank)]);

  a_r7_autopre_closes: assert property (@(posedge clk) disable iff (!rstN)
    (apEn && !(actEn && actBank == apBank)) |=> !openMask[$past(apBank)]);

  a_r8_preall_clears: assert property (@(posedge clk) disable iff (!rstN)
    preAllEn |=> (openMask == '0));

  a_r9_refresh_clears: assert property (@(posedge clk) disable iff (!rstN)
    refEn |=> (openMask == '0));

  a_r11_quiet_is_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!actEn && !preEn && !apEn && !preAllEn && !refEn && !$rose(rstN)) |=> $stable(openMask));

endmodule

bind bank_row_tracker bank_row_tracker_chk #(.BANKS(BANKS), .ROW_W(ROW_W)) u_chk (.*);

// File: tb/bank_row_tracker_bench.sv
`timescale 1ns/1ps
module bank_row_tracker_bench;

  localparam int BANKS  = 4;
  localparam int ROW_W  = 3;
  localparam int BANK_W = 2;
  localparam int ROWS   = 1 << ROW_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [BANK_W-1:0] qBank = '0;
  logic [ROW_W-1:0]  qRow = '0;
  logic [1:0]        qResult;
  logic [ROW_W-1:0]  qOpenRow;
  logic              actEn = 1'b0;
  logic [BANK_W-1:0] actBank = '0;
  logic [ROW_W-1:0]  actRow = '0;
  logic              preEn = 1'b0;
  logic [BANK_W-1:0] preBank = '0;
  logic              apEn = 1'b0;
  logic [BANK_W-1:0] apBank = '0;
  logic              preAllEn = 1'b0;
  logic              refEn = 1'b0;
  logic [BANKS-1:0]  openMask;

  always #2 clk = ~clk;

  bank_row_tracker #(.BANKS(BANKS), .ROW_W(ROW_W)) u_bank_row_tracker (.*);

  int runCount = 0;
  int failCount = 0;
  logic [BANKS-1:0] expOpen = '0;
  logic [ROW_W-1:0] expRow [BANKS];

  task automatic check(input string tag, input int act, input int exp);
    runCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sweep(input string maskTag);
    check(maskTag, int'(openMask), int'(expOpen));
    for (int b = 0; b < BANKS; b++) begin
      for (int r = 0; r < ROWS; r++) begin
        qBank = BANK_W'(b);
        qRow  = ROW_W'(r);
        #0.1;
        if (!expOpen[b]) begin
          check("R3 idle code", int'(qResult), 1);
          check("R5 closed row zero", int'(qOpenRow), 0);
        end else begin
          if (expRow[b] == ROW_W'(r)) check("R2 hit code", int'(qResult), 0);
          else check("R4 conflict code", int'(qResult), 2);
          check("R5 open row", int'(qOpenRow), int'(expRow[b]));
        end
      end
    end
  endtask

  task automatic ev(input bit a, input int aB, input int aR, input bit p, input int pB,
                    input bit ap, input int apB, input bit all, input bit rf);
    @(negedge clk);
    actEn = a; actBank = BANK_W'(aB); actRow = ROW_W'(aR);
    preEn = p; preBank = BANK_W'(pB);
    apEn = ap; apBank = BANK_W'(apB);
    preAllEn = all; refEn = rf;
    if (all || rf) begin
      expOpen = '0;
    end else begin
      if (p && !(a && aB == pB)) expOpen[pB] = 1'b0;
      if (ap && !(a && aB == apB)) expOpen[apB] = 1'b0;
      if (a) begin expOpen[aB] = 1'b1; expRow[aB] = ROW_W'(aR); end
    end
    @(negedge clk);
    actEn = 1'b0; preEn = 1'b0; apEn = 1'b0; preAllEn = 1'b0; refEn = 1'b0;
  endtask

  initial begin
    #800000;
    failCount++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int b = 0; b < BANKS; b++) expRow[b] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    sweep("R1 reset mask");

    // R5 open every bank with its own row (R11 independence)
    for (int b = 0; b < BANKS; b++) ev(1, b, b + 1, 0, 0, 0, 0, 0, 0);
    sweep("R11 all banks open");
    ev(1, 2, 6, 0, 0, 0, 0, 0, 0);
    sweep("R5 reactivate replaces row");
    ev(0, 0, 0, 1, 1, 0, 0, 0, 0);
    sweep("R6 precharge one bank");
    ev(0, 0, 0, 0, 0, 1, 2, 0, 0);
    sweep("R7 autoprecharge one bank");
    ev(0, 0, 0, 0, 0, 0, 0, 0, 0);
    sweep("R11 quiet cycle");
    ev(1, 0, 7, 1, 0, 1, 0, 0, 0);
    sweep("R10 activate beats precharge");
    ev(0, 0, 0, 0, 0, 0, 0, 0, 1);
    sweep("R9 refresh clears");
    for (int b = 0; b < BANKS; b++) ev(1, b, 3 * b, 0, 0, 0, 0, 0, 0);
    ev(0, 0, 0, 0, 0, 0, 0, 1, 0);
    sweep("R8 precharge-all clears");
    ev(1, 3, 5, 0, 0, 0, 0, 0, 0);
    ev(1, 1, 4, 0, 0, 0, 0, 1, 0);
    sweep("R10 close-all beats activate");
    ev(1, 2, 4, 0, 0, 0, 0, 0, 1);
    sweep("R10 refresh beats activate");

    lfsr = 16'hACE1;
    for (int i = 0; i < 120; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ev(lfsr[0] | lfsr[1], int'(lfsr[3:2]), int'(lfsr[6:4]),
         lfsr[7] & lfsr[8], int'(lfsr[10:9]),
         lfsr[11] & lfsr[12], int'(lfsr[14:13]),
         (lfsr[15:12] == 4'hF), (lfsr[11:8] == 4'h0));
      sweep("R11 mixed sequence mask");
    end

    $display("[TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end

endmodule